// File: doc/BRIEF.md
# Transactional Line Cache with Commit and Abort

This block is a small fully associative cache that serves the transactional memory operations of one processor. It accepts three access operations (transactional load, load for ownership, transactional store) and three control operations (commit, abort, validate). Every line that a transaction touches is held as two entries with the same address. One entry keeps the committed copy and is dropped when the transaction commits. The other entry takes the speculative copy and is dropped when the transaction aborts. Each entry also carries a coherence state: invalid, valid (shared and clean), dirty (exclusive and modified) or reserved (exclusive and clean).

Because each line has both copies, a commit or an abort is one retag of every entry in a single clock cycle. On a miss, the block places a read or read-for-ownership request on a shared-bus port and holds it until the bus answers. The answer is either an acknowledge with data or a busy indication. A busy answer, or a lack of free entries, marks the transaction as failed. Two processor flags are visible at the ports. `tx_active` means a transaction is in progress. `tx_status` means the transaction is still healthy.

The controller is a four-state machine:
- ST_IDLE (ready for a request) goes to ST_LOOK when a request arrives.
- ST_LOOK (tag search, allocation and control operations) goes to ST_BUS on a miss with two free entries. In every other case it goes to ST_DONE.
- ST_BUS (request held on the bus) goes to ST_DONE when the bus answers with an acknowledge or with busy.
- ST_DONE (one-cycle response) always returns to ST_IDLE.

Top module: `txcache_top`

## Requirements
- R1: After reset, `tx_active` is 0, `tx_status` is 1, `req_ready` is 1 and `bus_req` is 0, and every entry is empty.
- R2: A transactional load (`req_op`=0) that misses issues one bus cycle with `bus_rfo`=0 and returns `bus_rdata` with `rsp_ok`=1. A later load of the same address in the same transaction hits the speculative copy and issues no bus cycle.
- R3: A load that hits a committed (normal) entry returns the committed value with no bus cycle, and it creates the speculative/committed pair.
- R4: A load for ownership (`req_op`=1) or a store (`req_op`=2) that misses issues its bus cycle with `bus_rfo`=1.
- R5: A store returns the value the line held before the store, and it writes only the speculative copy. Later loads in the same transaction see the new value. After an abort, the value from before the transaction is seen again.
- R6: A commit (`req_op`=3) while `tx_status` is 1 returns `rsp_ok`=1 and keeps every speculative copy as the committed value.
- R7: A busy bus answer ends the access with `rsp_ok`=0 and `rsp_data`=0 and clears `tx_status`. While `tx_status` is 0, accesses return `rsp_ok`=0 and issue no bus cycle.
- R8: Validate (`req_op`=5) returns `tx_status` in `rsp_ok`. If `tx_status` is 0, validate also sets `tx_active` to 0 and `tx_status` to 1. If `tx_status` is 1, the flags are left unchanged.
- R9: A commit while `tx_status` is 0 returns `rsp_ok`=0 and discards the speculative copies, so earlier values remain.
- R10: An access that needs an entry when only transaction-owned entries remain fails with `rsp_ok`=0, clears `tx_status` and issues no bus cycle.
- R11: The first access of a transaction sets `tx_active`. Commit and abort (`req_op`=4) clear `tx_active` and leave `tx_status` at 1. Abort returns `rsp_ok`=1. `tx_active` is never 0 while `tx_status` is 0.
- R12: `req_ready` is high only in the idle state. `rsp_valid` is a one-cycle pulse. `bus_req` and `bus_addr` are held steady until `bus_ack` or `bus_busy`, and `bus_addr` is the address of the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operation request |
| req_ready | output | 1 | Block is idle and takes the request |
| req_op | input | 3 | 0 load, 1 load for ownership, 2 store, 3 commit, 4 abort, 5 validate |
| req_addr | input | ADDR_W | Line address of an access |
| req_wdata | input | DATA_W | Store data |
| rsp_valid | output | 1 | Response pulse |
| rsp_data | output | DATA_W | Loaded value, or the value before a store; 0 for failed accesses and control operations |
| rsp_ok | output | 1 | Access success, or the returned transaction status |
| tx_active | output | 1 | Transaction in progress flag |
| tx_status | output | 1 | Transaction healthy flag |
| bus_req | output | 1 | Bus cycle request |
| bus_rfo | output | 1 | 1 for read-for-ownership, 0 for shared read |
| bus_addr | output | ADDR_W | Bus cycle address |
| bus_ack | input | 1 | Bus cycle completed with data |
| bus_busy | input | 1 | Bus cycle refused |
| bus_rdata | input | DATA_W | Data returned with `bus_ack` |

## Verification
The bench drives accesses to the same line across several transactions in sequence. The first transaction misses, the next finds a committed entry, and later ones find speculative copies. This separates the three lookup outcomes by counting bus cycles. A store followed by commit is set against a store followed by abort, which shows which of the two copies survives each resolution. Failure is reached in two ways: by a busy bus answer, and by filling every entry with transaction-owned lines. Each failure is then followed by validate or commit, to show the returned status and the discard of speculative data.

// File: rtl/txc_pkg.sv
package txc_pkg;

    typedef enum logic [1:0] {
        TG_EMPTY   = 2'd0,
        TG_NORMAL  = 2'd1,
        TG_XCOMMIT = 2'd2,
        TG_XABORT  = 2'd3
    } tag_e;

    typedef enum logic [1:0] {
        CS_INVALID  = 2'd0,
        CS_VALID    = 2'd1,
        CS_DIRTY    = 2'd2,
        CS_RESERVED = 2'd3
    } coh_e;

    typedef enum logic [2:0] {
        OP_LOAD     = 3'd0,
        OP_LOADX    = 3'd1,
        OP_STORE    = 3'd2,
        OP_COMMIT   = 3'd3,
        OP_ABORT    = 3'd4,
        OP_VALIDATE = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_BUS  = 2'd2,
        ST_DONE = 2'd3
    } fsm_e;

endpackage

// File: rtl/txc_lookup.sv
module txc_lookup
    import txc_pkg::*;
#(
    parameter int N_ENTRIES = 4,
    parameter int ADDR_W    = 8,
    localparam int IW       = $clog2(N_ENTRIES)
) (
    input  tag_e              tags_i  [N_ENTRIES],
    input  logic [ADDR_W-1:0] addrs_i [N_ENTRIES],
    input  logic [ADDR_W-1:0] key_i,
    output logic              hit_xa_o,
    output logic [IW-1:0]     idx_xa_o,
    output logic              hit_nm_o,
    output logic [IW-1:0]     idx_nm_o
);

    logic [N_ENTRIES-1:0] match;

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
        assign match[g] = (tags_i[g] != TG_EMPTY) && (addrs_i[g] == key_i);
    end

    always_comb begin
        hit_xa_o = 1'b0;
        idx_xa_o = '0;
        hit_nm_o = 1'b0;
        idx_nm_o = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (match[i] && tags_i[i] == TG_XABORT) begin
                hit_xa_o = 1'b1;
                idx_xa_o = IW'(i);
            end
            if (match[i] && tags_i[i] == TG_NORMAL) begin
                hit_nm_o = 1'b1;
                idx_nm_o = IW'(i);
            end
        end
    end

endmodule

// File: rtl/txc_alloc.sv
module txc_alloc
    import txc_pkg::*;
#(
    parameter int N_ENTRIES = 4,
    localparam int IW       = $clog2(N_ENTRIES)
) (
    input  tag_e                 tags_i [N_ENTRIES],
    input  logic [N_ENTRIES-1:0] excl_i,
    output logic                 v0_o,
    output logic [IW-1:0]        i0_o,
    output logic                 v1_o,
    output logic [IW-1:0]        i1_o
);

    logic [N_ENTRIES-1:0] emp, nrm, emp2, nrm2;

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cls
        assign emp[g] = (tags_i[g] == TG_EMPTY)  && !excl_i[g];
        assign nrm[g] = (tags_i[g] == TG_NORMAL) && !excl_i[g];
    end

    // Empty entries win over committed ones; lowest index wins inside a class.
    always_comb begin
        v0_o = 1'b0;
        i0_o = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (nrm[i]) begin v0_o = 1'b1; i0_o = IW'(i); end
        end
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (emp[i]) begin v0_o = 1'b1; i0_o = IW'(i); end
        end
        emp2 = emp & ~(N_ENTRIES'(1) << i0_o);
        nrm2 = nrm & ~(N_ENTRIES'(1) << i0_o);
        v1_o = 1'b0;
        i1_o = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (nrm2[i]) begin v1_o = 1'b1; i1_o = IW'(i); end
        end
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (emp2[i]) begin v1_o = 1'b1; i1_o = IW'(i); end
        end
    end

endmodule

// File: rtl/txcache_top.sv
module txcache_top
    import txc_pkg::*;
#(
    parameter int N_ENTRIES = 4,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    localparam int IW       = $clog2(N_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_ok,
    output logic              tx_active,
    output logic              tx_status,
    output logic              bus_req,
    output logic              bus_rfo,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_ack,
    input  logic              bus_busy,
    input  logic [DATA_W-1:0] bus_rdata
);

    fsm_e              state_q, state_d;
    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [IW-1:0]     slot0_q, slot1_q;
    logic              act_q, sts_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rok_q;

    tag_e              tags_q  [N_ENTRIES];
    coh_e              coh_q   [N_ENTRIES];
    logic [ADDR_W-1:0] addrs_q [N_ENTRIES];
    logic [DATA_W-1:0] datas_q [N_ENTRIES];

    logic              hit_xa, hit_nm;
    logic [IW-1:0]     idx_xa, idx_nm;
    logic              a_v0, a_v1;
    logic [IW-1:0]     a_i0, a_i1;
    logic [N_ENTRIES-1:0] excl;

    logic is_access, look_fail, go_bus, do_resolve, resolve_keep;

    txc_lookup #(.N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W)) u_lookup (
        .tags_i  (tags_q),
        .addrs_i (addrs_q),
        .key_i   (addr_q),
        .hit_xa_o(hit_xa),
        .idx_xa_o(idx_xa),
        .hit_nm_o(hit_nm),
        .idx_nm_o(idx_nm)
    );

    assign excl = hit_nm ? (N_ENTRIES'(1) << idx_nm) : '0;

    txc_alloc #(.N_ENTRIES(N_ENTRIES)) u_alloc (
        .tags_i(tags_q),
        .excl_i(excl),
        .v0_o  (a_v0),
        .i0_o  (a_i0),
        .v1_o  (a_v1),
        .i1_o  (a_i1)
    );

    // Decision signals for the lookup and bus states.
    always_comb begin
        is_access    = (op_q == OP_LOAD) || (op_q == OP_LOADX) || (op_q == OP_STORE);
        look_fail    = is_access && sts_q && !hit_xa &&
                       ((hit_nm && !a_v0) || (!hit_nm && !(a_v0 && a_v1)));
        go_bus       = is_access && sts_q && !hit_xa && !hit_nm && a_v0 && a_v1;
        do_resolve   = 1'b0;
        resolve_keep = 1'b0;
        if (state_q == ST_LOOK) begin
            if (op_q == OP_COMMIT) begin
                do_resolve   = 1'b1;
                resolve_keep = sts_q;
            end else if (op_q == OP_ABORT || look_fail) begin
                do_resolve = 1'b1;
            end
        end else if (state_q == ST_BUS && bus_busy && !bus_ack) begin
            do_resolve = 1'b1;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_LOOK;
            ST_LOOK: state_d = go_bus ? ST_BUS : ST_DONE;
            ST_BUS:  if (bus_ack || bus_busy) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Entries, flags and response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_LOAD;
            addr_q  <= '0;
            wdata_q <= '0;
            slot0_q <= '0;
            slot1_q <= '0;
            act_q   <= 1'b0;
            sts_q   <= 1'b1;
            rdata_q <= '0;
            rok_q   <= 1'b0;
            for (int i = 0; i < N_ENTRIES; i++) begin
                tags_q[i]  <= TG_EMPTY;
                coh_q[i]   <= CS_INVALID;
                addrs_q[i] <= '0;
                datas_q[i] <= '0;
            end
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        op_q    <= op_e'(req_op);
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                    end
                end
                ST_LOOK: begin
                    rdata_q <= '0;
                    rok_q   <= 1'b0;
                    if (op_q == OP_COMMIT) begin
                        rok_q <= sts_q;
                        act_q <= 1'b0;
                        sts_q <= 1'b1;
                    end else if (op_q == OP_ABORT) begin
                        rok_q <= 1'b1;
                        act_q <= 1'b0;
                        sts_q <= 1'b1;
                    end else if (op_q == OP_VALIDATE) begin
                        rok_q <= sts_q;
                        if (!sts_q) begin
                            act_q <= 1'b0;
                            sts_q <= 1'b1;
                        end
                    end else if (is_access) begin
                        act_q <= 1'b1;
                        if (look_fail) begin
                            sts_q <= 1'b0;
                        end else if (sts_q && hit_xa) begin
                            rok_q   <= 1'b1;
                            rdata_q <= datas_q[idx_xa];
                            if (op_q == OP_STORE) begin
                                datas_q[idx_xa] <= wdata_q;
                                coh_q[idx_xa]   <= CS_DIRTY;
                            end
                        end else if (sts_q && hit_nm) begin
                            rok_q          <= 1'b1;
                            rdata_q        <= datas_q[idx_nm];
                            tags_q[idx_nm] <= TG_XABORT;
                            tags_q[a_i0]   <= TG_XCOMMIT;
                            addrs_q[a_i0]  <= addr_q;
                            datas_q[a_i0]  <= datas_q[idx_nm];
                            if (op_q == OP_LOAD) begin
                                coh_q[a_i0] <= coh_q[idx_nm];
                            end else begin
                                coh_q[a_i0]   <= CS_RESERVED;
                                coh_q[idx_nm] <= (op_q == OP_STORE) ? CS_DIRTY : CS_RESERVED;
                            end
                            if (op_q == OP_STORE) datas_q[idx_nm] <= wdata_q;
                        end else if (go_bus) begin
                            slot0_q <= a_i0;
                            slot1_q <= a_i1;
                        end
                    end
                end
                ST_BUS: begin
                    if (bus_ack) begin
                        rok_q            <= 1'b1;
                        rdata_q          <= bus_rdata;
                        tags_q[slot0_q]  <= TG_XCOMMIT;
                        tags_q[slot1_q]  <= TG_XABORT;
                        addrs_q[slot0_q] <= addr_q;
                        addrs_q[slot1_q] <= addr_q;
                        datas_q[slot0_q] <= bus_rdata;
                        datas_q[slot1_q] <= (op_q == OP_STORE) ? wdata_q : bus_rdata;
                        unique case (op_q)
                            OP_LOAD: begin
                                coh_q[slot0_q] <= CS_VALID;
                                coh_q[slot1_q] <= CS_VALID;
                            end
                            OP_STORE: begin
                                coh_q[slot0_q] <= CS_RESERVED;
                                coh_q[slot1_q] <= CS_DIRTY;
                            end
                            default: begin
                                coh_q[slot0_q] <= CS_RESERVED;
                                coh_q[slot1_q] <= CS_RESERVED;
                            end
                        endcase
                    end else if (bus_busy) begin
                        rok_q   <= 1'b0;
                        rdata_q <= '0;
                        sts_q   <= 1'b0;
                    end
                end
                ST_DONE: ;
                default: ;
            endcase

            // Bulk retag: keep speculative copies on success, committed ones otherwise.
            if (do_resolve) begin
                for (int i = 0; i < N_ENTRIES; i++) begin
                    unique case (tags_q[i])
                        TG_XCOMMIT: begin
                            if (resolve_keep) begin
                                tags_q[i] <= TG_EMPTY;
                                coh_q[i]  <= CS_INVALID;
                            end else begin
                                tags_q[i] <= TG_NORMAL;
                            end
                        end
                        TG_XABORT: begin
                            if (resolve_keep) begin
                                tags_q[i] <= TG_NORMAL;
                            end else begin
                                tags_q[i] <= TG_EMPTY;
                                coh_q[i]  <= CS_INVALID;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // Outputs.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        rsp_valid = (state_q == ST_DONE);
        rsp_data  = rdata_q;
        rsp_ok    = rok_q;
        tx_active = act_q;
        tx_status = sts_q;
        bus_req   = (state_q == ST_BUS);
        bus_rfo   = (op_q != OP_LOAD);
        bus_addr  = addr_q;
    end

endmodule

// File: rtl/txc_checker.sv
module txc_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              tx_active,
    input logic              tx_status,
    input logic              bus_req,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_ack,
    input logic              bus_busy
);

    AST_READY_NOT_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && rsp_valid)); // R12

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R12

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack && !bus_busy) |=> (bus_req && $stable(bus_addr))); // R12

    AST_NO_BUS_FAILED: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_status |-> !bus_req); // R7

    AST_FLAG_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |-> tx_status); // R11

    AST_BUS_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !req_ready); // R12

endmodule

bind txcache_top txc_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .tx_active(tx_active),
    .tx_status(tx_status),
    .bus_req  (bus_req),
    .bus_addr (bus_addr),
    .bus_ack  (bus_ack),
    .bus_busy (bus_busy)
);

// File: tb/txcache_top_tb_top.sv
module txcache_top_tb_top;

    localparam int AW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [2:0]    req_op = 3'd0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic          rsp_ok;
    logic          tx_active, tx_status;
    logic          bus_req, bus_rfo;
    logic [AW-1:0] bus_addr;
    logic          bus_ack = 1'b0;
    logic          bus_busy = 1'b0;
    logic [DW-1:0] bus_rdata = '0;

    int n_vec  = 0;
    int n_fail = 0;
    int bus_cnt = 0;
    logic          last_rfo = 1'b0;
    logic [AW-1:0] last_addr = '0;
    logic          busy_mode = 1'b0;
    logic          done = 1'b0;

    logic [DW-1:0] q_data [$];
    logic          q_ok   [$];
    string         q_req  [$];

    always #10 clk = ~clk;

    txcache_top #(.N_ENTRIES(4), .ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ok(rsp_ok),
        .tx_active(tx_active), .tx_status(tx_status),
        .bus_req(bus_req), .bus_rfo(bus_rfo), .bus_addr(bus_addr),
        .bus_ack(bus_ack), .bus_busy(bus_busy), .bus_rdata(bus_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Bus responder: answers two cycles after a request appears.
    initial begin
        forever begin
            @(negedge clk);
            if (bus_req) begin
                bus_cnt++;
                last_rfo  = bus_rfo;
                last_addr = bus_addr;
                repeat (2) @(negedge clk);
                if (busy_mode) bus_busy = 1'b1;
                else begin
                    bus_ack   = 1'b1;
                    bus_rdata = {8'hA0, last_addr};
                end
                @(negedge clk);
                bus_ack  = 1'b0;
                bus_busy = 1'b0;
            end
        end
    end

    // Monitor: pops expected responses.
    initial begin
        forever begin
            @(negedge clk);
            if (rsp_valid) begin
                if (q_req.size() == 0) begin
                    check("R12 unexpected response", 32'(rsp_valid), 32'd0);
                end else begin
                    automatic string r = q_req.pop_front();
                    automatic logic [DW-1:0] ed = q_data.pop_front();
                    automatic logic eo = q_ok.pop_front();
                    check({r, " ok"}, 32'(rsp_ok), 32'(eo));
                    check({r, " data"}, 32'(rsp_data), 32'(ed));
                end
            end
        end
    end

    // Driver: pushes the expectation and waits for it to be consumed.
    task automatic issue(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                         input logic [DW-1:0] exp_d, input logic exp_ok, input string req);
        q_req.push_back(req);
        q_data.push_back(exp_d);
        q_ok.push_back(exp_ok);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = a;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        while (q_req.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        int b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 tx_active", 32'(tx_active), 32'd0);
        check("R1 tx_status", 32'(tx_status), 32'd1);
        check("R1 req_ready", 32'(req_ready), 32'd1);
        check("R1 bus_req", 32'(bus_req), 32'd0);

        // R2: miss then hit on speculative copy
        b = bus_cnt;
        issue(3'd0, 8'h10, '0, 16'hA010, 1'b1, "R2 load miss");
        check("R2 bus cycles", 32'(bus_cnt), 32'(b + 1));
        check("R2 rfo", 32'(last_rfo), 32'd0);
        check("R12 bus_addr", 32'(last_addr), 32'h10);
        check("R11 active set", 32'(tx_active), 32'd1);
        issue(3'd0, 8'h10, '0, 16'hA010, 1'b1, "R2 load hit");
        check("R2 no bus on hit", 32'(bus_cnt), 32'(b + 1));

        // R5/R6: store then commit
        issue(3'd2, 8'h10, 16'h1234, 16'hA010, 1'b1, "R5 store old value");
        issue(3'd0, 8'h10, '0, 16'h1234, 1'b1, "R5 load sees store");
        issue(3'd3, 8'h00, '0, 16'h0000, 1'b1, "R6 commit ok");
        check("R11 commit clears active", 32'(tx_active), 32'd0);
        check("R11 commit status", 32'(tx_status), 32'd1);

        // R3: committed entry hit
        issue(3'd0, 8'h10, '0, 16'h1234, 1'b1, "R3 normal hit");
        check("R3 no bus", 32'(bus_cnt), 32'(b + 1));
        issue(3'd2, 8'h10, 16'h5555, 16'h1234, 1'b1, "R5 store on normal");
        issue(3'd0, 8'h10, '0, 16'h5555, 1'b1, "R5 load new");
        issue(3'd4, 8'h00, '0, 16'h0000, 1'b1, "R11 abort");
        check("R11 abort clears active", 32'(tx_active), 32'd0);
        issue(3'd0, 8'h10, '0, 16'h1234, 1'b1, "R5 abort restores");
        check("R5 no bus", 32'(bus_cnt), 32'(b + 1));
        issue(3'd3, 8'h00, '0, 16'h0000, 1'b1, "R6 commit ok 2");

        // R4: ownership misses
        issue(3'd1, 8'h20, '0, 16'hA020, 1'b1, "R4 loadx miss");
        check("R4 loadx rfo", 32'(last_rfo), 32'd1);
        issue(3'd2, 8'h30, 16'h7777, 16'hA030, 1'b1, "R4 store miss");
        check("R4 store rfo", 32'(last_rfo), 32'd1);
        check("R4 bus cycles", 32'(bus_cnt), 32'(b + 3));

        // R10: capacity exhausted
        issue(3'd0, 8'h40, '0, 16'h0000, 1'b0, "R10 no entry");
        check("R10 no bus", 32'(bus_cnt), 32'(b + 3));
        check("R10 status cleared", 32'(tx_status), 32'd0);
        issue(3'd0, 8'h20, '0, 16'h0000, 1'b0, "R7 access after failure");
        check("R7 no bus after failure", 32'(bus_cnt), 32'(b + 3));
        issue(3'd3, 8'h00, '0, 16'h0000, 1'b0, "R9 commit fails");
        check("R9 flags active", 32'(tx_active), 32'd0);
        check("R9 flags status", 32'(tx_status), 32'd1);
        issue(3'd0, 8'h30, '0, 16'hA030, 1'b1, "R9 store discarded");
        check("R9 no bus", 32'(bus_cnt), 32'(b + 3));
        issue(3'd4, 8'h00, '0, 16'h0000, 1'b1, "R11 abort 2");

        // R7: busy answer
        busy_mode = 1'b1;
        issue(3'd0, 8'h50, '0, 16'h0000, 1'b0, "R7 busy");
        busy_mode = 1'b0;
        check("R7 busy bus cycle", 32'(bus_cnt), 32'(b + 4));
        check("R7 status cleared", 32'(tx_status), 32'd0);
        issue(3'd0, 8'h51, '0, 16'h0000, 1'b0, "R7 later access");
        check("R7 no bus", 32'(bus_cnt), 32'(b + 4));

        // R8: validate
        issue(3'd5, 8'h00, '0, 16'h0000, 1'b0, "R8 validate false");
        check("R8 active cleared", 32'(tx_active), 32'd0);
        check("R8 status restored", 32'(tx_status), 32'd1);
        issue(3'd0, 8'h20, '0, 16'hA020, 1'b1, "R3 committed after abort");
        issue(3'd5, 8'h00, '0, 16'h0000, 1'b1, "R8 validate true");
        check("R8 active kept", 32'(tx_active), 32'd1);
        issue(3'd3, 8'h00, '0, 16'h0000, 1'b1, "R6 commit ok 3");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule